// File: doc/BRIEF.md
# Duty-Gated Energy Accumulator

This block measures how much of a fixed time window a pulse-width-modulated heater drive spends switched on. Every clock cycle in which the drive is high adds one to an accumulator. When the window closes, the total is a fraction of full heater power. The block subtracts a fixed offset from that total, scales it into output units and presents the reading together with a one-cycle strobe. The next window starts on the following cycle, so no clock is skipped between windows.

A typical use is a constant-temperature airflow sensor. A control loop keeps a heated element just above ambient, so the energy the loop delivers equals the heat carried away by the moving air. The reading therefore tracks airflow. Window length, offset and scale are plain inputs. They are sampled when a window closes and can be changed between windows.

Top module: `duty_energy_meter`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0 and `valid` is 0 until the first window closes.
- R2: `valid` is high for one cycle at the end of each window, and consecutive pulses are exactly `win_len` cycles apart. A `win_len` of 0 acts as 1, so with 0 or 1 `valid` is high every cycle.
- R3: The count for a window is the number of its cycles in which the synchronized drive is high. A level sampled on `pwm_in` at a clock edge takes part in counting two edges later.
- R4: A cycle with the synchronized drive low leaves the count unchanged. A window with the drive low throughout reads 0.
- R5: Windows follow each other with no gap and no overlap. With the drive always high, every window counts exactly `win_len`.
- R6: Removing the offset saturates at zero. A count not above `offset` gives a result of 0.
- R7: The result is (count − offset) × `scale`, shifted right by `SHIFT` bits. A `scale` of 0 gives 0.
- R8: A scaled value that does not fit in `OUT_W` bits is reported as all ones.
- R9: `result` changes only in a cycle where `valid` is high, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Heater drive signal, asynchronous to clk |
| win_len | input | CNT_W | Window length in clock cycles |
| offset | input | CNT_W | Count subtracted before scaling |
| scale | input | SCALE_W | Unsigned multiplier |
| result | output | OUT_W | Scaled reading of the last completed window |
| valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The hardest cases to reach are the edges of the arithmetic at window close: a count that lands exactly on the offset, which must give zero and not wrap, and a product just past the output range, which must clamp. The bench reaches them by sweeping duty patterns, including all-high drive, against offsets of zero, mid-range and beyond the window length, and scales of 0, 1 and the maximum. Window lengths of 0 and 1 exercise the case where every cycle closes a window and the accumulator is cleared and loaded on the same edge. All settings change only in the cycle after a strobe. A reference model with the two-cycle input delay predicts each strobe and its value.

// File: rtl/duty_energy_meter.sv
module duty_energy_meter #(
  parameter int CNT_W   = 16,
  parameter int OUT_W   = 16,
  parameter int SCALE_W = 8,
  parameter int SHIFT   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_in,
  input  logic [CNT_W-1:0]   win_len,
  input  logic [CNT_W-1:0]   offset,
  input  logic [SCALE_W-1:0] scale,
  output logic [OUT_W-1:0]   result,
  output logic               valid
);
  localparam int PROD_W = CNT_W + SCALE_W;

  logic             sync1, sync2;
  logic [CNT_W-1:0] win_cnt, acc;

  wire [CNT_W-1:0] last_idx = (win_len == '0) ? '0 : win_len - 1'b1;
  wire             win_end  = (win_cnt >= last_idx);
  wire [CNT_W-1:0] total    = acc + CNT_W'(sync2);
  wire [CNT_W-1:0] net      = (total > offset) ? total - offset : '0;

  logic [PROD_W-1:0] prod, shifted;
  logic [OUT_W-1:0]  scaled;
  assign prod    = PROD_W'(net) * PROD_W'(scale);
  assign shifted = prod >> SHIFT;

  generate
    if (PROD_W > OUT_W) begin : g_clamp
      assign scaled = (|shifted[PROD_W-1:OUT_W]) ? '1 : shifted[OUT_W-1:0];
    end else begin : g_fit
      assign scaled = OUT_W'(shifted);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= pwm_in;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      acc     <= '0;
      result  <= '0;
      valid   <= 1'b0;
    end else if (win_end) begin
      win_cnt <= '0;
      acc     <= '0;
      result  <= scaled;
      valid   <= 1'b1;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      acc     <= total;
      valid   <= 1'b0;
    end
  end

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= win_cnt); // R3

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync2 && !win_end) |=> (acc == $past(acc))); // R4

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && win_len > 1 && $stable(win_len)) |=> !valid); // R2

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result)); // R9

  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(scale) == '0) |-> (result == '0)); // R7
endmodule

// File: tb/test_duty_energy_meter.sv
module test_duty_energy_meter;
  localparam int CNT_W = 8, OUT_W = 8, SCALE_W = 4, SHIFT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0;
  logic [CNT_W-1:0] win_len = 8'd4;
  logic [CNT_W-1:0] offset = '0;
  logic [SCALE_W-1:0] scale = 4'd4;
  logic [OUT_W-1:0] result;
  logic valid;

  int checks = 0, errors = 0, cycles = 0, mode = 0, duty = 0;
  string tag = "R3";

  always #2 clk = ~clk;

  duty_energy_meter #(.CNT_W(CNT_W), .OUT_W(OUT_W), .SCALE_W(SCALE_W), .SHIFT(SHIFT)) i_duty_energy_meter (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .win_len(win_len),
    .offset(offset), .scale(scale), .result(result), .valid(valid));

  function automatic int calc(int cnt, int off, int scl);
    int d, v;
    d = (cnt > off) ? cnt - off : 0;
    v = (d * scl) >> SHIFT;
    return (v > 255) ? 255 : v;
  endfunction

  // reference model
  logic m1 = 0, m2 = 0, exp_v = 0;
  int mcnt = 0, macc = 0, exp_res = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 0; m2 <= 0; mcnt <= 0; macc <= 0; exp_v <= 0; exp_res <= 0;
    end else begin
      m1 <= pwm_in;
      m2 <= m1;
      if (mcnt >= ((win_len == 0) ? 0 : int'(win_len) - 1)) begin
        exp_res <= calc(macc + int'(m2), int'(offset), int'(scale));
        exp_v <= 1; mcnt <= 0; macc <= 0;
      end else begin
        exp_v <= 0; mcnt <= mcnt + 1; macc <= macc + int'(m2);
      end
    end
  end

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic pattern(int c);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return c[0];
      3: return (c % 7) < duty;
      default: return ((c / 5) % 3) == 0;
    endcase
  endfunction

  always @(negedge clk) begin
    cycles++;
    pwm_in <= pattern(cycles);
    if (!rst_n) begin
      check("R1", int'(result), 0);
      check("R1", int'(valid), 0);
    end else begin
      check("R2", int'(valid), int'(exp_v));
      if (valid) check(tag, int'(result), exp_res);
      else check("R9", int'(result), exp_res);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(string t, int len, int off, int scl, int md, int d, int nwin);
    for (int w = 0; w < nwin; w++) begin
      do @(negedge clk); while (!valid);
      if (w == 0) begin
        tag = t; win_len = CNT_W'(len); offset = CNT_W'(off);
        scale = SCALE_W'(scl); mode = md; duty = d;
      end
    end
    do @(negedge clk); while (!valid);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run("R3", 4, 0, 4, 2, 0, 3);
    run("R4", 9, 0, 4, 0, 0, 3);
    run("R5", 16, 0, 4, 1, 0, 3);
    run("R5", 255, 0, 4, 1, 0, 2);
    run("R2", 1, 0, 4, 2, 0, 6);
    run("R2", 0, 0, 4, 4, 0, 6);
    for (int d = 0; d <= 7; d++) run("R3", 23, 0, 4, 3, d, 3);
    for (int l = 2; l <= 12; l++) run("R3", l, 1, 5, 4, 0, 3);
    run("R6", 10, 10, 15, 1, 0, 3);
    run("R6", 10, 9, 15, 1, 0, 3);
    run("R6", 10, 200, 15, 3, 4, 3);
    run("R7", 50, 0, 0, 1, 0, 3);
    run("R7", 50, 3, 1, 3, 5, 3);
    run("R7", 40, 5, 7, 2, 0, 3);
    run("R8", 68, 0, 15, 1, 0, 3);
    run("R8", 69, 0, 15, 1, 0, 3);
    run("R8", 200, 20, 15, 1, 0, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule